// File: doc/BRIEF.md
# Edge-Combining Impulse Pulse Former

This block is a discrete-time model of an impulse-radio transmitter front end. It runs on a fast tick clock, and one tick stands for one step of a delay line. On each symbol strobe it toggles a small bank of flip-flops, one tick apart. An XOR tree folds their outputs into a short logical pulse. An edge-enable mask picks which flip-flops toggle, and that choice sets the pulse shape. Two edges on neighbouring taps give a single narrow pulse. All four edges give an alternating high-low-high-low burst whose fundamental period is two ticks.

Each symbol carries two data bits. The position bit delays the whole pulse by a fixed offset of `PPM_TICKS` ticks. The polarity bit steers the pulse onto either the positive rail or the negative rail, and the other rail stays low. The mask, the position bit and the polarity bit are captured together when a strobe is accepted. They stay frozen until the last edge of that pulse has been launched.

A strobe that carries a mask with an odd number of set bits is refused, because the combined output would not return to zero. A strobe that arrives while a pulse is still being launched is dropped, and a one-cycle overrun flag reports it.

Top module: `edge_pulse_gen`

## Requirements
- R1: While the synchronous active-low reset is asserted, all flip-flop states clear, and after the reset edge both output rails and the overrun flag are 0.
- R2: An accepted strobe on clock edge n with mask 4'b0011, early position and positive polarity drives `out_pos` high for exactly one cycle, namely the cycle after edge n+1, and otherwise low.
- R3: With mask 4'b1111 and early position, the selected rail reads 1,0,1,0 in the four cycles after edges n+1 to n+4.
- R4: Mask bit k (bit 0 = first tap) toggles flip-flop k at launch offset k. The rail level in the cycle after edge n+1+L+j (L = position delay, j = 0..3) is the XOR of mask bits 0..j. Examples: 4'b0101 is high for 2 cycles and 4'b1001 is high for 3 cycles.
- R5: When the position bit is 1, the whole pulse pattern is shifted later by exactly `PPM_TICKS` cycles (default 10) compared with the early position.
- R6: Polarity bit 0 places the pulse on `out_pos` only, and polarity bit 1 places it on `out_neg` only. The two rails are never high together.
- R7: A strobe seen while idle whose mask has odd population count is refused. No pulse is produced, no overrun is raised, and a strobe on the very next cycle is accepted.
- R8: A strobe on any edge from n+1 through n+L+4 is ignored. The pulse in flight keeps its original shape, position and polarity, and `overrun` is 1 for the one cycle after that edge. A strobe on edge n+L+5 is accepted normally.
- R9: Changes on the mask, position and polarity inputs after the accepting edge have no effect on the pulse in flight.
- R10: Every accepted strobe yields exactly one pulse pattern. The rails are 0 whenever no pulse is being launched, including for an accepted all-zero mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock, one tick per delay step |
| rst_n | input | 1 | Synchronous active-low reset |
| sym_stb | input | 1 | Symbol strobe, one cycle per symbol |
| edge_mask | input | N_EDGES | Edge-enable mask selecting the pulse shape; bit k drives tap k |
| pos_late | input | 1 | Position bit: 1 delays the pulse by PPM_TICKS |
| pol_neg | input | 1 | Polarity bit: 0 positive rail, 1 negative rail |
| out_pos | output | 1 | Positive-polarity pulse rail |
| out_neg | output | 1 | Negative-polarity pulse rail |
| overrun | output | 1 | One-cycle flag: a strobe arrived while a pulse was in progress |

## Verification
The assertions assume that a strobe is a plain one-cycle request. They also assume that `SYM_TICKS` is large enough for the late launch window, so the launch counter never needs to pass `PPM_TICKS + 3`. Apart from that, the inputs may change at any time. The held-configuration and single-edge-per-tick checks therefore cover every pattern of input activity between strobes.

The stimulus sweeps several masks, both positions and both polarities. It scrambles the mask, position and polarity inputs on the cycle after every strobe. It deliberately sends odd masks, back-to-back strobes after a refusal, and strobes on the last busy edge and the first idle edge.

// File: rtl/pulse_gen_pkg.sv
// Package: shared types for the edge-combining pulse former.
// Assumes: nothing beyond being compiled before the modules that import it.
package pulse_gen_pkg;

    // Default number of delay-line taps (flip-flops) combined per pulse.
    localparam int DEF_EDGES = 4;

    // Per-symbol modulation settings captured on an accepted strobe.
    typedef struct packed {
        logic late;   // position bit: pulse launched PPM_TICKS later
        logic neg;    // polarity bit: pulse on the negative rail
    } sym_mod_t;

endpackage

// File: rtl/pulse_launch_ctrl.sv
// Module: pulse_launch_ctrl
// Accepts symbol strobes, captures mask and modulation bits, runs the launch
// counter and issues one toggle enable per tap at launch offset k.
// Assumes: SYM_TICKS > PPM_TICKS + N_EDGES - 1, so the counter never wraps.
module pulse_launch_ctrl
    import pulse_gen_pkg::*;
#(
    parameter int N_EDGES   = DEF_EDGES,
    parameter int PPM_TICKS = 10,
    parameter int SYM_TICKS = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sym_stb,
    input  logic [N_EDGES-1:0] edge_mask,
    input  logic               pos_late,
    input  logic               pol_neg,
    output logic [N_EDGES-1:0] fire,
    output logic               busy,
    output logic               neg_sel,
    output logic               overrun
);

    localparam int               CNT_W = $clog2(SYM_TICKS);
    localparam logic [CNT_W-1:0] PPM_C = CNT_W'(PPM_TICKS);
    localparam logic [CNT_W-1:0] SPAN  = CNT_W'(N_EDGES - 1);

    logic               busy_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [N_EDGES-1:0] mask_q;
    sym_mod_t           mod_q;
    logic               ovr_q;
    logic [CNT_W-1:0]   launch;
    logic [CNT_W-1:0]   last;
    logic               accept;

    // Launch offset and final tap index of the held symbol.
    always_comb begin
        launch = mod_q.late ? PPM_C : '0;
        last   = launch + SPAN;
    end

    // A strobe is taken only when idle and with an even mask population.
    assign accept = sym_stb && !busy_q && !(^edge_mask);

    // Capture settings, run the launch counter and flag overruns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            mask_q <= '0;
            mod_q  <= '0;
            ovr_q  <= 1'b0;
        end else begin
            ovr_q <= sym_stb && busy_q;
            if (accept) begin
                busy_q     <= 1'b1;
                cnt_q      <= '0;
                mask_q     <= edge_mask;
                mod_q.late <= pos_late;
                mod_q.neg  <= pol_neg;
            end else if (busy_q) begin
                if (cnt_q == last) begin
                    busy_q <= 1'b0;
                end
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // One toggle enable per tap: tap k fires at offset launch + k if enabled.
    for (genvar k = 0; k < N_EDGES; k++) begin : g_fire
        assign fire[k] = busy_q && mask_q[k] && (cnt_q == launch + CNT_W'(k));
    end

    assign busy    = busy_q;
    assign neg_sel = mod_q.neg;
    assign overrun = ovr_q;

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && $past(busy_q)) |-> ($stable(mask_q) && $stable(mod_q)));

    // R7
    odd_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_stb && !busy_q && (^edge_mask)) |=> !busy_q);

    // R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (cnt_q <= last));

endmodule

// File: rtl/edge_toggle_bank.sv
// Module: edge_toggle_bank
// One toggle flip-flop per delay-line tap. Each toggles when its enable
// is high, which models one staggered clock edge.
// Assumes: at most one enable is high per tick (taps are one tick apart).
module edge_toggle_bank #(
    parameter int N_EDGES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_EDGES-1:0] fire,
    output logic [N_EDGES-1:0] tap_q
);

    for (genvar k = 0; k < N_EDGES; k++) begin : g_tap
        // Toggle tap k on its launch tick; clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tap_q[k] <= 1'b0;
            end else if (fire[k]) begin
                tap_q[k] <= ~tap_q[k];
            end
        end
    end

    // R4
    one_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fire));

endmodule

// File: rtl/xor_fold_tree.sv
// Module: xor_fold_tree
// Balanced binary XOR tree folding N inputs into one logical pulse level.
// Heap layout: leaves sit at nodes N-1 .. 2N-2 and the root is node 0.
// Assumes: N_IN >= 2.
module xor_fold_tree #(
    parameter int N_IN = 4
) (
    input  logic [N_IN-1:0] leaf,
    output logic            root
);

    localparam int N_NODES = 2 * N_IN - 1;

    logic [N_NODES-1:0] node;

    // Place leaves at the bottom of the heap.
    for (genvar i = 0; i < N_IN; i++) begin : g_leaf
        assign node[N_IN-1+i] = leaf[i];
    end

    // Each internal node is a two-input XOR of its children.
    for (genvar i = 0; i < N_IN - 1; i++) begin : g_gate
        assign node[i] = node[2*i+1] ^ node[2*i+2];
    end

    assign root = node[0];

endmodule

// File: rtl/polarity_steer.sv
// Module: polarity_steer
// Two AND gates route the logical pulse to the positive or the negative rail.
// Assumes: neg_sel is stable for the whole pulse (held by the controller).
module polarity_steer (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse,
    input  logic neg_sel,
    output logic out_pos,
    output logic out_neg
);

    // Steer the pulse; the unused rail stays at 0.
    always_comb begin
        out_pos = pulse & ~neg_sel;
        out_neg = pulse &  neg_sel;
    end

    // R6
    rails_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_pos && out_neg));

endmodule

// File: rtl/edge_pulse_gen.sv
// Module: edge_pulse_gen (top)
// Edge-combining impulse pulse former. Strobe-captured mask selects which
// staggered taps toggle; an XOR tree forms the pulse; position delays it by
// PPM_TICKS; polarity picks the output rail.
// Assumes: SYM_TICKS > PPM_TICKS + N_EDGES - 1 and N_EDGES >= 2.
module edge_pulse_gen
    import pulse_gen_pkg::*;
#(
    parameter int N_EDGES   = DEF_EDGES,
    parameter int PPM_TICKS = 10,
    parameter int SYM_TICKS = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sym_stb,
    input  logic [N_EDGES-1:0] edge_mask,
    input  logic               pos_late,
    input  logic               pol_neg,
    output logic               out_pos,
    output logic               out_neg,
    output logic               overrun
);

    logic [N_EDGES-1:0] fire;
    logic [N_EDGES-1:0] tap_q;
    logic               busy;
    logic               neg_sel;
    logic               comb;

    pulse_launch_ctrl #(
        .N_EDGES  (N_EDGES),
        .PPM_TICKS(PPM_TICKS),
        .SYM_TICKS(SYM_TICKS)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .sym_stb  (sym_stb),
        .edge_mask(edge_mask),
        .pos_late (pos_late),
        .pol_neg  (pol_neg),
        .fire     (fire),
        .busy     (busy),
        .neg_sel  (neg_sel),
        .overrun  (overrun)
    );

    edge_toggle_bank #(
        .N_EDGES(N_EDGES)
    ) u_bank (
        .clk  (clk),
        .rst_n(rst_n),
        .fire (fire),
        .tap_q(tap_q)
    );

    xor_fold_tree #(
        .N_IN(N_EDGES)
    ) u_tree (
        .leaf(tap_q),
        .root(comb)
    );

    polarity_steer u_steer (
        .clk    (clk),
        .rst_n  (rst_n),
        .pulse  (comb),
        .neg_sel(neg_sel),
        .out_pos(out_pos),
        .out_neg(out_neg)
    );

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !comb);

endmodule

// File: tb/edge_pulse_gen_test.sv
// Bench: behavioural timeline model of the pulse former, compared every cycle.
module edge_pulse_gen_test;

    localparam int PPM = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sym_stb = 1'b0;
    logic [3:0] edge_mask = 4'b0000;
    logic       pos_late = 1'b0;
    logic       pol_neg = 1'b0;
    logic       out_pos, out_neg, overrun;

    int    checks = 0;
    int    errors = 0;
    bit    chk_en = 0;
    bit    done = 0;
    string cur_req = "R1";

    // reference model state
    int   ec = 0;
    bit   act_m = 0;
    int   acc_m, s_m, endb_m;
    logic [3:0] mask_m;
    bit   pol_m;
    bit   bz, lvl;
    bit   exp_pos = 0, exp_neg = 0, exp_ovr = 0;

    edge_pulse_gen #(.N_EDGES(4), .PPM_TICKS(PPM), .SYM_TICKS(16)) uut (
        .clk(clk), .rst_n(rst_n), .sym_stb(sym_stb), .edge_mask(edge_mask),
        .pos_late(pos_late), .pol_neg(pol_neg),
        .out_pos(out_pos), .out_neg(out_neg), .overrun(overrun)
    );

    always #5 clk = ~clk;

    // Reference model: timeline of launch offsets per accepted strobe.
    always @(posedge clk) begin
        ec++;
        if (!rst_n) begin
            act_m = 0; exp_pos = 0; exp_neg = 0; exp_ovr = 0;
        end else begin
            bz = act_m && (ec > acc_m) && (ec <= endb_m);
            exp_ovr = sym_stb && bz;
            if (sym_stb && !bz && !(^edge_mask)) begin
                act_m  = 1;
                acc_m  = ec;
                s_m    = ec + 1 + (pos_late ? PPM : 0);
                endb_m = s_m + 3;
                mask_m = edge_mask;
                pol_m  = pol_neg;
            end
            lvl = 0;
            if (act_m && ec >= s_m && ec <= s_m + 3) begin
                for (int j = 0; j <= ec - s_m; j++) lvl ^= mask_m[j];
            end
            exp_pos = lvl && !pol_m;
            exp_neg = lvl && pol_m;
        end
    end

    // Compare on the falling edge, away from the active edge.
    always @(negedge clk) begin
        if (chk_en && !done) begin
            checks++;
            if (out_pos !== exp_pos || out_neg !== exp_neg || overrun !== exp_ovr) begin
                errors++;
                $display("FAIL %s cycle %0d: pos/neg/ovr actual %b%b%b expected %b%b%b",
                         cur_req, ec, out_pos, out_neg, overrun, exp_pos, exp_neg, exp_ovr);
            end
        end
    end

    // Issue one strobe, scramble inputs afterwards (R9), then wait gap cycles.
    task automatic send(input logic [3:0] m, input bit late, input bit neg,
                        input string req, input int gap);
        @(negedge clk);
        cur_req = req;
        sym_stb = 1'b1; edge_mask = m; pos_late = late; pol_neg = neg;
        @(negedge clk);
        sym_stb = 1'b0; edge_mask = ~m; pos_late = !late; pol_neg = !neg;
        repeat (gap) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        checks++;
        if (out_pos !== 1'b0 || out_neg !== 1'b0 || overrun !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: actual %b%b%b expected 000", out_pos, out_neg, overrun);
        end
        rst_n = 1'b1;
        chk_en = 1;

        send(4'b0011, 0, 0, "R2", 20);
        send(4'b1111, 0, 0, "R3", 20);
        send(4'b0101, 0, 0, "R4", 20);
        send(4'b1001, 0, 0, "R4", 20);
        send(4'b0110, 0, 0, "R4", 20);
        send(4'b1100, 0, 0, "R4", 20);
        send(4'b0011, 1, 0, "R5", 20);
        send(4'b1111, 1, 1, "R5", 20);
        send(4'b0011, 0, 1, "R6", 20);
        send(4'b1111, 0, 1, "R6", 20);
        send(4'b0111, 0, 0, "R7", 0);
        send(4'b0011, 0, 0, "R7", 20);
        send(4'b1000, 1, 1, "R7", 0);
        send(4'b1010, 1, 1, "R7", 20);
        send(4'b1111, 1, 0, "R8", 3);
        send(4'b0011, 0, 1, "R8", 20);
        send(4'b1001, 1, 0, "R8", 12);   // next strobe lands on last busy edge
        send(4'b0011, 0, 0, "R8", 20);
        send(4'b0110, 1, 1, "R9", 13);   // next strobe lands on first idle edge
        send(4'b1111, 0, 0, "R9", 20);
        send(4'b0000, 0, 0, "R10", 20);
        for (int i = 0; i < 60; i++) begin
            logic [3:0] m;
            m = 4'($urandom_range(0, 15));
            send(m, bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)), "R10", 14);
        end
        repeat (20) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule